// File: doc/BRIEF.md
# Periodic Pulse and Interrupt Generator

This block turns the carry strobes of a time-of-day counter into one periodic signal for a host processor. A two-bit field picks which of four strobes (1/64 s, 1 s, 1 min, 1 h) starts an event. Each strobe arrives as a one-cycle pulse from the prescaler or the counter chain.

The output is an enable for an open-drain driver. A high value on `out_low_o` pulls the pin low, which means the output is asserted. A mode bit picks one of two behaviours:
- **Pulse mode:** the pin is held low for a fixed number of width strobes and then released by the block itself. With the defaults this is 8 strobes at 1024 Hz, or 7.8125 ms.
- **Interrupt mode:** the pin stays low until software writes 0 to the status flag.

The status flag always shows the pin state. A mask bit blocks new events and releases the pin. The block has no chip-select input, so the output keeps running while the bus side is in standby. Register decode is outside the block and reaches it as the control levels and a flag-write strobe.

Top module: `fp_pulse_gen`

## Requirements
- R1: After reset `out_low_o` and `irq_flag_o` are both 0.
- R2: `period_sel_i` selects the trigger strobe: 0 = `tick_64hz_i`, 1 = `tick_sec_i`, 2 = `tick_min_i`, 3 = `tick_hour_i`. The selected strobe, with the mask clear, sets `out_low_o` in the next cycle. Strobes that are not selected have no effect.
- R3: In pulse mode (`irq_mode_i`=0), `out_low_o` falls in the cycle after the PULSE_TICKS-th `tick_width_i` strobe that follows the trigger.
- R4: In interrupt mode (`irq_mode_i`=1), `out_low_o` stays 1 through any number of width strobes until a flag write of 0.
- R5: `irq_flag_o` equals `out_low_o` in every cycle.
- R6: A flag write (`flag_wr_i`=1) with `flag_wdata_i`=1 changes nothing. With `flag_wdata_i`=0 it clears the output in the next cycle, in either mode.
- R7: While `mask_i`=1, the output is 0 from the next cycle and no strobe sets it.
- R8: A trigger that arrives while the output is already set keeps it set and is not queued. A single clear releases it, and it stays released.
- R9: In pulse mode, a trigger during a running pulse restarts the width count at PULSE_TICKS.
- R10: A trigger and a clear-write in the same cycle leave the output set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_64hz_i | input | 1 | 1/64 s strobe |
| tick_sec_i | input | 1 | Seconds carry strobe |
| tick_min_i | input | 1 | Minutes carry strobe |
| tick_hour_i | input | 1 | Hours carry strobe |
| tick_width_i | input | 1 | Strobe that times the pulse width |
| period_sel_i | input | 2 | Period select |
| irq_mode_i | input | 1 | 0 = self-ending pulse, 1 = latched interrupt |
| mask_i | input | 1 | Blocks new events and releases the output |
| flag_wr_i | input | 1 | Write strobe for the status flag |
| flag_wdata_i | input | 1 | Data written to the status flag |
| out_low_o | output | 1 | Open-drain pull-down enable (1 = pin low) |
| irq_flag_o | output | 1 | Status flag |

## Verification
The assertions assume every strobe input is one clock wide and synchronous to `clk_i`. They also assume the control levels only change between edges. The stimulus drives every input on the falling edge. It raises each strobe for a single cycle, with low probability, so that pulses can both finish and be restarted. Mode, mask and select change freely, including during a pending event, because the requirements define the result in every such cycle.

// File: rtl/fp_pkg.sv
package fp_pkg;
  typedef enum logic [1:0] {
    PER_64HZ = 2'b00,
    PER_SEC  = 2'b01,
    PER_MIN  = 2'b10,
    PER_HOUR = 2'b11
  } period_e;

  localparam int unsigned NUM_PERIODS = 4;
endpackage

// File: rtl/fp_tick_sel.sv
module fp_tick_sel
  import fp_pkg::*;
(
  input  logic [NUM_PERIODS-1:0] tick_i,
  input  period_e                sel_i,
  input  logic                   mask_i,
  output logic                   fire_o
);
  logic [NUM_PERIODS-1:0] hit;

  for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_hit
    assign hit[g] = tick_i[g] && (sel_i == period_e'(g));
  end

  assign fire_o = |hit && !mask_i;
endmodule

// File: rtl/fp_width_cnt.sv
module fp_width_cnt #(
  parameter int unsigned PULSE_TICKS = 8,
  localparam int unsigned CNT_W = $clog2(PULSE_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic kill_i,
  input  logic step_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_TICKS);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = step_i && !load_i && !kill_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (kill_i)   cnt_q <= '0;
    else if (load_i)   cnt_q <= LOAD_VAL;
    else if (step_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD_VAL);

  a_r9_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !kill_i |=> cnt_q == LOAD_VAL);
endmodule

// File: rtl/fp_out_ctl.sv
module fp_out_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic mask_i,
  input  logic clr_i,
  input  logic expire_i,
  output logic active_o
);
  logic active_q;

  // priority: mask, trigger, software clear, pulse expiry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       active_q <= 1'b0;
    else if (mask_i)   active_q <= 1'b0;
    else if (fire_i)   active_q <= 1'b1;
    else if (clr_i || expire_i) active_q <= 1'b0;
  end

  assign active_o = active_q;

  a_r7_mask_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |=> !active_o);

  a_r2_set_needs_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o && !fire_i |=> !active_o);

  a_r10_fire_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> active_o);
endmodule

// File: rtl/fp_pulse_gen.sv
module fp_pulse_gen
  import fp_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_64hz_i,
  input  logic       tick_sec_i,
  input  logic       tick_min_i,
  input  logic       tick_hour_i,
  input  logic       tick_width_i,
  input  logic [1:0] period_sel_i,
  input  logic       irq_mode_i,
  input  logic       mask_i,
  input  logic       flag_wr_i,
  input  logic       flag_wdata_i,
  output logic       out_low_o,
  output logic       irq_flag_o
);
  logic fire, clr, expire, active, step;

  fp_tick_sel u_sel (
    .tick_i ({tick_hour_i, tick_min_i, tick_sec_i, tick_64hz_i}),
    .sel_i  (period_e'(period_sel_i)),
    .mask_i (mask_i),
    .fire_o (fire)
  );

  // only a written 0 clears; a written 1 is ignored
  assign clr  = flag_wr_i && !flag_wdata_i;
  assign step = tick_width_i && !irq_mode_i && active;

  fp_width_cnt #(.PULSE_TICKS(PULSE_TICKS)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (fire),
    .kill_i (mask_i || (clr && !fire)),
    .step_i (step),
    .done_o (expire)
  );

  fp_out_ctl u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .mask_i   (mask_i),
    .clr_i    (clr),
    .expire_i (expire),
    .active_o (active)
  );

  assign out_low_o  = active;
  assign irq_flag_o = active;

  a_r4_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_low_o && irq_mode_i && !mask_i && !clr |=> out_low_o);

  a_r6_write_one_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_low_o && flag_wr_i && flag_wdata_i && irq_mode_i && !mask_i |=> out_low_o);

  a_r6_write_zero_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_wr_i && !flag_wdata_i && !fire |=> !out_low_o);
endmodule

// File: tb/tb_fp_pulse_gen.sv
module tb_fp_pulse_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PT = 8;

  logic clk = 0, rst_n = 0;
  logic [3:0] tk;
  logic tw, mode, mask, fwr, fwd;
  logic [1:0] psel;
  logic out_low, flag;
  int n_chk = 0, n_err = 0;
  int seed = 1234;
  logic m_act;
  int m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_pulse_gen #(.PULSE_TICKS(PT)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tick_64hz_i(tk[0]), .tick_sec_i(tk[1]), .tick_min_i(tk[2]), .tick_hour_i(tk[3]),
    .tick_width_i(tw), .period_sel_i(psel), .irq_mode_i(mode), .mask_i(mask),
    .flag_wr_i(fwr), .flag_wdata_i(fwd), .out_low_o(out_low), .irq_flag_o(flag));

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_step();
    logic fire, clr;
    fire = tk[psel] && !mask;
    clr  = fwr && !fwd;
    if (mask) begin m_act = 0; m_cnt = 0; end
    else if (fire) begin m_act = 1; m_cnt = PT; end
    else if (clr) begin m_act = 0; m_cnt = 0; end
    else if (m_act && !mode && tw) begin
      if (m_cnt <= 1) begin m_act = 0; m_cnt = 0; end
      else m_cnt--;
    end
  endfunction

  task automatic idle();
    tk = 0; tw = 0; mask = 0; fwr = 0; fwd = 1;
  endtask

  // inputs already set at a falling edge; advance one cycle and compare
  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(out_low, m_act, "R2 model");
    chk(flag, out_low, "R5 flag mirrors output");
    idle();
  endtask

  task automatic fire_now();
    tk[psel] = 1; cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    idle(); psel = 0; mode = 0; m_act = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    chk(out_low, 0, "R1 reset out"); chk(flag, 0, "R1 reset flag");
    rst_n = 1;
    @(negedge clk);
    chk(out_low, 0, "R1 after release");

    // R2: only the selected strobe triggers
    mode = 1;
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        psel = 2'(s); mask = 1; cyc();
        tk[t] = 1; cyc();
        chk(out_low, (s == t), "R2 select");
      end
    end

    // R3 pulse width
    mask = 1; cyc(); mode = 0; psel = 1;
    fire_now(); chk(out_low, 1, "R3 start");
    for (int i = 0; i < PT - 1; i++) begin tw = 1; cyc(); cyc(); end
    chk(out_low, 1, "R3 before last strobe");
    tw = 1; cyc(); chk(out_low, 0, "R3 released");

    // R9 retrigger
    fire_now();
    for (int i = 0; i < 5; i++) begin tw = 1; cyc(); end
    fire_now();
    for (int i = 0; i < PT - 1; i++) begin tw = 1; cyc(); end
    chk(out_low, 1, "R9 restarted count");
    tw = 1; cyc(); chk(out_low, 0, "R9 release");

    // R4 / R6 interrupt hold and clear
    mode = 1; fire_now();
    for (int i = 0; i < 3 * PT; i++) begin tw = 1; cyc(); end
    chk(out_low, 1, "R4 held");
    fwr = 1; fwd = 1; cyc(); chk(out_low, 1, "R6 write one ignored");
    fwr = 1; fwd = 0; cyc(); chk(out_low, 0, "R6 write zero clears");
    chk(flag, 0, "R5 flag clear");

    // R6 clear ends a pulse early
    mode = 0; fire_now(); tw = 1; cyc();
    fwr = 1; fwd = 0; cyc(); chk(out_low, 0, "R6 clear in pulse mode");

    // R8 no queueing
    mode = 1; fire_now(); fire_now(); chk(out_low, 1, "R8 still set");
    fwr = 1; fwd = 0; cyc(); chk(out_low, 0, "R8 single clear");
    cyc(); cyc(); chk(out_low, 0, "R8 stays released");

    // R10 trigger beats clear
    fire_now(); tk[psel] = 1; fwr = 1; fwd = 0; cyc();
    chk(out_low, 1, "R10 trigger wins");

    // R7 mask
    mask = 1; cyc(); chk(out_low, 0, "R7 mask releases");
    mask = 1; tk = 4'hf; cyc(); chk(out_low, 0, "R7 masked strobe");
    fwr = 1; fwd = 0; cyc();

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      tk   = 4'(($urandom(seed) % 8 == 0) ? (1 << ($urandom % 4)) : 0);
      seed = 0;
      tw   = ($urandom % 3 == 0);
      mask = ($urandom % 40 == 0);
      fwr  = ($urandom % 12 == 0);
      fwd  = $urandom % 2;
      if ($urandom % 50 == 0) mode = ~mode;
      if ($urandom % 60 == 0) psel = 2'($urandom);
      cyc();
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule